// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block sits beside the transmit arbiter of one Ethernet port and decides which of the eight priority queues may fetch frame data at any moment. It works through a list of gate commands held in a double-buffered command store. Each command names a set of open priorities and the number of transmitted units for which that set stays open. The unit is a byte at gigabit speed and a nibble at 10 or 100 Mb/s. The arbiter pulses `unit_tick_i` once for each unit it moves. An external periodic time base pulses `cycle_start_i` at every schedule cycle boundary. On each pulse the engine restarts from the first command of the buffer that software has selected.

Software fills the idle half of the store through a small write port and then points the select bit at it. The engine adopts the new half only at the next cycle boundary. The `active_buf_o` status lets software see when the hand-over has happened: it has happened once that status equals `sel_buf_o`. A long gate interval is written as several consecutive commands with the same mask. A zero-count command closes the list. Software normally uses it to open the priorities that no timed command used, and they stay open until the cycle restarts.

Top module: `tas_gate_engine`

## Requirements
- R1: While `en_i` is low, `allow_mask_o` is all ones from the next clock on, and cycle-start pulses and unit ticks have no effect on it.
- R2: `unit_nibble_o` is high when `gig_mode_i` is low (units are nibbles) and low when `gig_mode_i` is high (units are bytes).
- R3: A command word carries the allowed-priority mask in bits 7:0 and the unit count in bits 27:8. On the clock after a cycle-start pulse with the engine enabled, `allow_mask_o` shows the mask of entry 0 of the selected buffer.
- R4: A command with count N (N ≥ 16) keeps its mask for exactly N unit ticks. The tick that ends it loads the next entry's mask.
- R5: A nonzero count below 16 lasts exactly 16 unit ticks.
- R6: A command with a zero count puts its mask on `allow_mask_o` and holds it until the next cycle-start pulse. Entries after it have no effect.
- R7: A cycle-start pulse that arrives while commands remain discards them and restarts from entry 0 with that entry's full count.
- R8: A host write to address bit 7 = 1 sets the buffer select to data bit 0. RAM writes use address bit 7 = 0, with bit 6 as the buffer and bits 5:0 as the entry. While the engine is enabled, `active_buf_o` takes the select value only on a cycle-start pulse. While it is disabled, `active_buf_o` follows the select on the next clock.
- R9: After `en_i` rises, `allow_mask_o` stays all ones until the first cycle-start pulse.
- R10: When the count of entry 63 runs out, its mask is held until the next cycle-start pulse.
- R11: When a cycle-start pulse and a unit tick arrive on the same clock, the pulse wins and the tick is not counted against entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable |
| gig_mode_i | input | 1 | Link runs at 1 Gb/s |
| cycle_start_i | input | 1 | Cycle boundary pulse from the time base |
| unit_tick_i | input | 1 | One transmit unit moved by the arbiter |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 8 | Host address: bit 7 control, bit 6 buffer, bits 5:0 entry |
| host_wdata_i | input | 32 | Host write data |
| allow_mask_o | output | 8 | Priorities allowed to fetch |
| unit_nibble_o | output | 1 | Counts are in nibbles |
| sel_buf_o | output | 1 | Buffer select as written by the host |
| active_buf_o | output | 1 | Buffer the engine runs from |

## Verification
The list is run from a cycle-start pulse with a steady stream of ticks. The commands in it have a count of 20, a count of 5 that must stretch to 16, a count of 18 and a closing zero-count command. This separates exact count handling, clamping and termination. Pulses are also placed mid-list and on the same clock as a tick, which separates restart and priority between the two events. A switch to a fully populated second buffer exercises deferred adoption and end-of-buffer hold. Disabled operation and speed changes show the all-ones override and the unit indication.

// File: rtl/tas_gate_pkg.sv
package tas_gate_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,  // not started since enable
    SEQ_RUN  = 2'd1,  // timed command counting
    SEQ_HOLD = 2'd2   // list ended, mask held
  } seq_state_e;
endpackage

// File: rtl/tas_cmd_store.sv
module tas_cmd_store #(
  parameter int WORD_W  = 32,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wbuf_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rbuf_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem_q [ENTRIES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
      end else if (we_i && (wbuf_i == b[0])) begin
        mem_q[widx_i] <= wdata_i;
      end
    end
    assign bank_rd[b] = mem_q[ridx_i];
  end

  assign rdata_o = rbuf_i ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/tas_cmd_decode.sv
module tas_cmd_decode #(
  parameter int WORD_W  = 32,
  parameter int PRIO_W  = 8,
  parameter int CNT_LSB = 8,
  parameter int CNT_W   = 20,
  parameter int MIN_CNT = 16
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [PRIO_W-1:0] mask_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              last_o
);
  localparam int TOP = CNT_LSB + CNT_W;

  logic [CNT_W-1:0] raw_cnt;

  assign mask_o  = word_i[PRIO_W-1:0];
  assign raw_cnt = word_i[TOP-1:CNT_LSB];
  assign last_o  = (raw_cnt == '0);
  // short nonzero counts are stretched to the minimum
  assign cnt_o   = (!last_o && raw_cnt < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : raw_cnt;

  if (TOP < WORD_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^word_i[WORD_W-1:TOP];
  end
  if (CNT_LSB > PRIO_W) begin : g_mid
    logic unused_mid;
    assign unused_mid = ^word_i[CNT_LSB-1:PRIO_W];
  end
endmodule

// File: rtl/tas_gate_seq.sv
module tas_gate_seq
  import tas_gate_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int CNT_W   = 20,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cs_i,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic [PRIO_W-1:0] cmd_mask_i,
  input  logic [CNT_W-1:0]  cmd_cnt_i,
  input  logic              cmd_last_i,
  output logic              rd_buf_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [PRIO_W-1:0] mask_o,
  output logic              active_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  rem_q;
  logic [PRIO_W-1:0] mask_q;
  logic              active_q;

  always_comb begin
    rd_buf_o = active_q;
    rd_idx_o = idx_q + 1'b1;
    if (cs_i) begin
      rd_buf_o = sel_i;
      rd_idx_o = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      idx_q    <= '0;
      rem_q    <= '0;
      mask_q   <= '1;
      active_q <= 1'b0;
    end else if (!en_i) begin
      state_q  <= SEQ_IDLE;
      mask_q   <= '1;
      active_q <= sel_i;
    end else if (cs_i) begin
      active_q <= sel_i;
      idx_q    <= '0;
      mask_q   <= cmd_mask_i;
      rem_q    <= cmd_cnt_i;
      state_q  <= cmd_last_i ? SEQ_HOLD : SEQ_RUN;
    end else if (state_q == SEQ_RUN && tick_i) begin
      if (rem_q != CNT_W'(1)) begin
        rem_q <= rem_q - 1'b1;
      end else if (idx_q == LAST_IDX) begin
        state_q <= SEQ_HOLD;
      end else begin
        idx_q   <= idx_q + 1'b1;
        mask_q  <= cmd_mask_i;
        rem_q   <= cmd_cnt_i;
        state_q <= cmd_last_i ? SEQ_HOLD : SEQ_RUN;
      end
    end
  end

  assign mask_o   = mask_q;
  assign active_o = active_q;
endmodule

// File: rtl/tas_gate_engine.sv
module tas_gate_engine #(
  parameter int WORD_W   = 32,
  parameter int PRIO_W   = 8,
  parameter int CNT_LSB  = 8,
  parameter int CNT_W    = 20,
  parameter int MIN_CNT  = 16,
  parameter int ENTRIES  = 64,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int HOST_AW = IDX_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               gig_mode_i,
  input  logic               cycle_start_i,
  input  logic               unit_tick_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [WORD_W-1:0]  host_wdata_i,
  output logic [PRIO_W-1:0]  allow_mask_o,
  output logic               unit_nibble_o,
  output logic               sel_buf_o,
  output logic               active_buf_o
);
  logic              ctl_we, ram_we, sel_q;
  logic              rd_buf;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic [PRIO_W-1:0] cmd_mask;
  logic [CNT_W-1:0]  cmd_cnt;
  logic              cmd_last;

  assign ctl_we = host_we_i &  host_addr_i[HOST_AW-1];
  assign ram_we = host_we_i & ~host_addr_i[HOST_AW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (ctl_we) sel_q <= host_wdata_i[0];
  end

  tas_cmd_store #(.WORD_W(WORD_W), .ENTRIES(ENTRIES)) store_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ram_we),
    .wbuf_i  (host_addr_i[HOST_AW-2]),
    .widx_i  (host_addr_i[IDX_W-1:0]),
    .wdata_i (host_wdata_i),
    .rbuf_i  (rd_buf),
    .ridx_i  (rd_idx),
    .rdata_o (rd_word)
  );

  tas_cmd_decode #(
    .WORD_W(WORD_W), .PRIO_W(PRIO_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W), .MIN_CNT(MIN_CNT)
  ) decode_i (
    .word_i (rd_word),
    .mask_o (cmd_mask),
    .cnt_o  (cmd_cnt),
    .last_o (cmd_last)
  );

  tas_gate_seq #(.PRIO_W(PRIO_W), .CNT_W(CNT_W), .ENTRIES(ENTRIES)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cs_i       (cycle_start_i),
    .tick_i     (unit_tick_i),
    .sel_i      (sel_q),
    .cmd_mask_i (cmd_mask),
    .cmd_cnt_i  (cmd_cnt),
    .cmd_last_i (cmd_last),
    .rd_buf_o   (rd_buf),
    .rd_idx_o   (rd_idx),
    .mask_o     (allow_mask_o),
    .active_o   (active_buf_o)
  );

  assign sel_buf_o     = sel_q;
  assign unit_nibble_o = ~gig_mode_i;
endmodule

// File: rtl/tas_gate_engine_chk.sv
module tas_gate_engine_chk #(
  parameter int PRIO_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              cycle_start_i,
  input logic              unit_tick_i,
  input logic [PRIO_W-1:0] allow_mask_o,
  input logic              sel_buf_o,
  input logic              active_buf_o
);
  // R1
  disabled_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> allow_mask_o == '1);

  // R8
  swap_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_buf_o) |-> $past(cycle_start_i || !en_i));

  // R8
  swap_takes_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cycle_start_i) |=> active_buf_o == $past(sel_buf_o));

  // R4
  mask_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(allow_mask_o) |-> $past(!en_i || cycle_start_i || unit_tick_i));
endmodule

bind tas_gate_engine tas_gate_engine_chk #(.PRIO_W(PRIO_W)) chk_i (.*);

// File: tb/tas_gate_engine_tb.sv
module tas_gate_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, gig = 1'b1, cs = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  mask;
  logic        nib, selb, actb;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tas_gate_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .gig_mode_i(gig),
    .cycle_start_i(cs), .unit_tick_i(tick), .host_we_i(we),
    .host_addr_i(addr), .host_wdata_i(wdata),
    .allow_mask_o(mask), .unit_nibble_o(nib), .sel_buf_o(selb), .active_buf_o(actb)
  );

  // behavioural reference
  logic [31:0] m_ram [2][64];
  logic [7:0]  m_mask;
  logic        m_sel, m_act, m_run;
  int          m_idx, m_rem;

  task automatic m_load(int i);
    logic [31:0] w;
    int c;
    w = m_ram[m_act][i];
    m_idx = i;
    m_mask = w[7:0];
    c = int'(w[27:8]);
    if (c == 0) m_run = 1'b0;
    else begin
      m_run = 1'b1;
      m_rem = (c < 16) ? 16 : c;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) for (int i = 0; i < 64; i++) m_ram[b][i] = '0;
      m_mask = 8'hFF; m_sel = 0; m_act = 0; m_run = 0; m_idx = 0; m_rem = 0;
    end else begin
      if (!en) begin
        m_mask = 8'hFF; m_run = 0; m_act = m_sel;
      end else if (cs) begin
        m_act = m_sel;
        m_load(0);
      end else if (m_run && tick) begin
        if (m_rem > 1) m_rem--;
        else if (m_idx == 63) m_run = 0;
        else m_load(m_idx + 1);
      end
      if (we) begin
        if (addr[7]) m_sel = wdata[0];
        else m_ram[addr[6]][addr[5:0]] = wdata;
      end
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison with the reference
  always @(negedge clk) if (rst_n && !done) begin
    chk(cur_req, "model mask", mask, m_mask);
    chk(cur_req, "model active", {7'd0, actb}, {7'd0, m_act});
    chk(cur_req, "model sel", {7'd0, selb}, {7'd0, m_sel});
    chk("R2", "model nibble", {7'd0, nib}, {7'd0, ~gig});
  end

  task automatic step(logic c, logic t);
    cs = c; tick = t;
    @(negedge clk);
    cs = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 1);
  endtask

  task automatic hwr(logic [7:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  function automatic logic [31:0] cmd(logic [7:0] m, int c);
    return {4'd0, 20'(c), m};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset mask", mask, 8'hFF);
    chk("R8", "reset active", {7'd0, actb}, 8'd0);
    chk("R2", "reset nibble", {7'd0, nib}, 8'd0);

    cur_req = "R1";
    step(1, 1); step(1, 0);
    chk("R1", "disabled pulse", mask, 8'hFF);

    hwr(8'h00, cmd(8'h01, 20));
    hwr(8'h01, cmd(8'h02, 5));
    hwr(8'h02, cmd(8'h04, 18));
    hwr(8'h03, cmd(8'hF8, 0));
    hwr(8'h04, cmd(8'h55, 30));

    en = 1'b1;
    cur_req = "R9";
    step(0, 1); step(0, 0);
    chk("R9", "before first pulse", mask, 8'hFF);

    cur_req = "R3";
    step(1, 0);
    chk("R3", "entry0 mask", mask, 8'h01);
    cur_req = "R4";
    ticks(19);
    chk("R4", "entry0 held", mask, 8'h01);
    ticks(1);
    chk("R4", "entry1 loaded", mask, 8'h02);
    cur_req = "R5";
    ticks(15);
    chk("R5", "short count stretched", mask, 8'h02);
    ticks(1);
    chk("R5", "after 16", mask, 8'h04);
    cur_req = "R6";
    ticks(18);
    chk("R6", "end mask", mask, 8'hF8);
    ticks(40);
    chk("R6", "later entries ignored", mask, 8'hF8);

    cur_req = "R7";
    step(1, 0);
    ticks(10);
    step(1, 0);
    chk("R7", "restart mask", mask, 8'h01);
    ticks(19);
    chk("R7", "full count after restart", mask, 8'h01);
    ticks(1);
    chk("R7", "next after restart", mask, 8'h02);

    cur_req = "R11";
    step(1, 1);
    ticks(19);
    chk("R11", "tick ignored at pulse", mask, 8'h01);
    ticks(1);
    chk("R11", "advance on 20th", mask, 8'h02);

    cur_req = "R8";
    for (int i = 0; i < 63; i++) hwr(8'h40 | 8'(i), cmd(8'h80 | 8'(i), 16));
    hwr(8'h7F, cmd(8'hA5, 16));
    hwr(8'h80, 32'd1);
    chk("R8", "sel written", {7'd0, selb}, 8'd1);
    chk("R8", "active unchanged", {7'd0, actb}, 8'd0);
    ticks(3);
    chk("R8", "active before boundary", {7'd0, actb}, 8'd0);
    step(1, 0);
    chk("R8", "active after boundary", {7'd0, actb}, 8'd1);
    chk("R8", "new buffer entry0", mask, 8'h80);

    cur_req = "R10";
    ticks(63 * 16);
    chk("R10", "entry63 mask", mask, 8'hA5);
    ticks(16 + 30);
    chk("R10", "held after last", mask, 8'hA5);

    cur_req = "R2";
    gig = 1'b0;
    step(0, 0);
    chk("R2", "nibble at low speed", {7'd0, nib}, 8'd1);
    gig = 1'b1;
    step(0, 0);
    chk("R2", "byte at gigabit", {7'd0, nib}, 8'd0);

    cur_req = "R1";
    en = 1'b0;
    step(0, 1);
    chk("R1", "disable opens all", mask, 8'hFF);
    step(1, 1);
    chk("R1", "pulse ignored", mask, 8'hFF);
    cur_req = "R8";
    hwr(8'h80, 32'd0);
    step(0, 0);
    chk("R8", "disabled follows sel", {7'd0, actb}, 8'd0);

    finish_run();
  end
endmodule